// File: doc/BRIEF.md
# Programmable Two-Mode Clock Prescaler

This block turns a fast clock into a slow, programmable periodic tick for a downstream timer. Each of its channels holds a 16-bit divide value N, a 3-bit select value M, an enable bit and a source bit. All of these are loaded by a single write strobe. The source bit chooses what a count cycle is. It is either two system clock periods, or one rising edge of that channel's external clock after a two-flop synchroniser and edge detector.

With M equal to zero the channel runs a narrow pulse train. Each period has one low count cycle and N−1 high count cycles. The pin output stays low, and only the internal tick carries the train. With M from 1 to 7 the channel makes a symmetric square wave on its pin. Each half-period is N·2^(M−1) count cycles long. In both modes the internal tick is a one-system-cycle strobe that fires whenever the internal level goes from high to low.

Each channel has a three-state machine. OFF is the disabled state. LOW is the first part of a period, and HIGH is the second part. The transitions are:
- WRITE_ON: any state to LOW, on a write with enable set.
- WRITE_OFF: any state to OFF, on a write with enable clear.
- LOW_DONE: LOW to HIGH, when the low phase count runs out.
- HIGH_DONE: HIGH to LOW, when the high phase count runs out. This transition issues the tick.

Top module: `tick_prescaler`

## Requirements
- R1: After reset, every tick and pin output is 0 and stays 0 until a write with enable set.
- R2: With M = 0, the tick repeats every N count cycles: one low count cycle followed by N−1 high count cycles. The pin output stays 0 the whole time.
- R3: With M from 1 to 7, the pin output is a square wave. It is high for N·2^(M−1) count cycles and low for N·2^(M−1) count cycles, and the tick repeats once per full wave.
- R4: With the source bit at 0, one count cycle is two system clock periods. After a write, the first count cycle ends on the second clock edge.
- R5: With the source bit at 1, one count cycle is one rising edge of the channel's external clock after two synchroniser flops. The external clock must be slower than half the system clock.
- R6: The tick is high for exactly one system clock cycle for each HIGH-to-LOW transition. In square-wave mode it is high in the same cycle that the pin output falls.
- R7: A write with enable set restarts the channel. In the cycle after the write edge the pin output is 0, and the full low phase is counted from that edge. With the source bit at 0, N = 3 and M = 1, the pin stays 0 for 6 system cycles and is 1 in the 7th.
- R8: A write with enable clear forces the channel to OFF. The tick and pin outputs then stay 0 regardless of the external clock.
- R9: If N is below 2, every phase length that would be 0 is raised to 1 count cycle, so the channel keeps running. For example, N = 0 with M = 0 gives a tick every 2 count cycles.
- R10: Channels are independent. A write strobe loads only the channel whose bit in `cfg_we` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | NCH | Per-channel write strobe for the configuration fields |
| cfg_div | input | N_W | Divide value N |
| cfg_sel | input | M_W | Select value M (0 = pulse mode) |
| cfg_en | input | 1 | Enable bit loaded on write |
| cfg_ext | input | 1 | Count source: 0 = half-rate system clock, 1 = external clock |
| ext_clk | input | NCH | Per-channel external count clock |
| tick | output | NCH | One-cycle strobe at each high-to-low transition |
| pin_out | output | NCH | Square-wave pin output, held low when M = 0 |

## Verification
The bench measures tick spacing and pin high time in system cycles across both modes and several values of N and M. A shift that is off by one in square-wave mode would double or halve the measured period. A pulse mode that leaked onto the pin would show a nonzero high time. A restart issued in the middle of a high phase must drop the pin at once and hold it low for exactly the low-phase length. A design that only reloaded the counter, without resetting the half-rate phase, would come out one cycle off. The bench also covers the external source at a known edge rate, the disabled state with the external clock still toggling, and N of 0. A design without clamping would stall or wrap its counter at N of 0 and never tick again.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } psc_state_e;

endpackage

// File: rtl/psc_count_src.sv
module psc_count_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic use_ext,
    input  logic ext_clk,
    output logic cnt_en
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ext_last_q;
    logic                   half_q;
    logic                   ext_rise;

    // synchroniser chain, length chosen by parameter
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ext_clk;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_last_q <= 1'b0;
            half_q     <= 1'b0;
        end else begin
            ext_last_q <= sync_q[SYNC_STAGES-1];
            half_q     <= restart ? 1'b0 : ~half_q;
        end
    end

    assign ext_rise = sync_q[SYNC_STAGES-1] & ~ext_last_q;
    assign cnt_en   = use_ext ? ext_rise : half_q;

endmodule

// File: rtl/psc_phase_len.sv
module psc_phase_len #(
    parameter int N_W = 16,
    parameter int M_W = 3,
    localparam int CW = N_W + (1 << M_W) - 2
) (
    input  logic [N_W-1:0] div,
    input  logic [M_W-1:0] sel,
    output logic [CW-1:0]  low_len,
    output logic [CW-1:0]  high_len
);
    logic [CW-1:0] div_w;
    logic [CW-1:0] half_w;
    logic [M_W-1:0] shamt;

    assign div_w = {{(CW-N_W){1'b0}}, div};
    assign shamt = sel - M_W'(1);

    always_comb begin
        half_w = div_w << shamt;
        if (sel == '0) begin
            low_len  = CW'(1);
            high_len = (div_w > CW'(1)) ? (div_w - CW'(1)) : CW'(1);
        end else begin
            low_len  = (half_w == '0) ? CW'(1) : half_w;
            high_len = low_len;
        end
    end

endmodule

// File: rtl/psc_channel.sv
module psc_channel
    import psc_pkg::*;
#(
    parameter int N_W = 16,
    parameter int M_W = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [N_W-1:0] wr_div,
    input  logic [M_W-1:0] wr_sel,
    input  logic           wr_en,
    input  logic           wr_ext,
    input  logic           ext_clk,
    output logic           tick,
    output logic           pin
);
    localparam int CW = N_W + (1 << M_W) - 2;

    psc_state_e     st_q, st_n;
    logic [CW-1:0]  rem_q, rem_n;
    logic [N_W-1:0] div_q;
    logic [M_W-1:0] sel_q, sel_n;
    logic           ext_q;
    logic           cnt_en;
    logic           fall_n;
    logic           tick_q, pin_q;
    logic [CW-1:0]  w_low, w_high, q_low, q_high;

    psc_count_src #(.SYNC_STAGES(SYNC_STAGES)) src_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (we),
        .use_ext (ext_q),
        .ext_clk (ext_clk),
        .cnt_en  (cnt_en)
    );

    psc_phase_len #(.N_W(N_W), .M_W(M_W)) wr_len_i (
        .div      (wr_div),
        .sel      (wr_sel),
        .low_len  (w_low),
        .high_len (w_high)
    );

    psc_phase_len #(.N_W(N_W), .M_W(M_W)) run_len_i (
        .div      (div_q),
        .sel      (sel_q),
        .low_len  (q_low),
        .high_len (q_high)
    );

    // configuration fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            sel_q <= '0;
            ext_q <= 1'b0;
        end else if (we) begin
            div_q <= wr_div;
            sel_q <= wr_sel;
            ext_q <= wr_ext;
        end
    end

    // next state: WRITE_ON, WRITE_OFF, LOW_DONE, HIGH_DONE
    always_comb begin
        st_n   = st_q;
        rem_n  = rem_q;
        fall_n = 1'b0;
        if (we) begin
            if (wr_en) begin
                st_n  = ST_LOW;
                rem_n = w_low;
            end else begin
                st_n  = ST_OFF;
                rem_n = '0;
            end
        end else begin
            unique case (st_q)
                ST_OFF: begin
                    rem_n = '0;
                end
                ST_LOW: begin
                    if (cnt_en) begin
                        if (rem_q <= CW'(1)) begin
                            st_n  = ST_HIGH;
                            rem_n = q_high;
                        end else begin
                            rem_n = rem_q - CW'(1);
                        end
                    end
                end
                ST_HIGH: begin
                    if (cnt_en) begin
                        if (rem_q <= CW'(1)) begin
                            st_n   = ST_LOW;
                            rem_n  = q_low;
                            fall_n = 1'b1;
                        end else begin
                            rem_n = rem_q - CW'(1);
                        end
                    end
                end
                default: begin
                    st_n  = ST_OFF;
                    rem_n = '0;
                end
            endcase
        end
    end

    assign sel_n = we ? wr_sel : sel_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            rem_q <= '0;
        end else begin
            st_q  <= st_n;
            rem_q <= rem_n;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
            pin_q  <= 1'b0;
        end else begin
            tick_q <= fall_n;
            pin_q  <= (st_n == ST_HIGH) && (sel_n != '0);
        end
    end

    assign tick = tick_q;
    assign pin  = pin_q;

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int NCH = 2,
    parameter int N_W = 16,
    parameter int M_W = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cfg_we,
    input  logic [N_W-1:0] cfg_div,
    input  logic [M_W-1:0] cfg_sel,
    input  logic           cfg_en,
    input  logic           cfg_ext,
    input  logic [NCH-1:0] ext_clk,
    output logic [NCH-1:0] tick,
    output logic [NCH-1:0] pin_out
);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            psc_channel #(
                .N_W         (N_W),
                .M_W         (M_W),
                .SYNC_STAGES (SYNC_STAGES)
            ) chan_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .we      (cfg_we[c]),
                .wr_div  (cfg_div),
                .wr_sel  (cfg_sel),
                .wr_en   (cfg_en),
                .wr_ext  (cfg_ext),
                .ext_clk (ext_clk[c]),
                .tick    (tick[c]),
                .pin     (pin_out[c])
            );
        end
    endgenerate

endmodule

// File: rtl/psc_chk.sv
module psc_chk #(
    parameter int NCH = 2,
    parameter int N_W = 16,
    parameter int M_W = 3,
    parameter int SYNC_STAGES = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] cfg_we,
    input logic [N_W-1:0] cfg_div,
    input logic [M_W-1:0] cfg_sel,
    input logic           cfg_en,
    input logic           cfg_ext,
    input logic [NCH-1:0] ext_clk,
    input logic [NCH-1:0] tick,
    input logic [NCH-1:0] pin_out
);
    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ck
            logic [M_W-1:0] sel_seen_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)         sel_seen_q <= '0;
                else if (cfg_we[i]) sel_seen_q <= cfg_sel;
            end

            a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
                tick[i] |=> !tick[i]);

            a_r6_fall_ticks: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(pin_out[i]) && !$past(cfg_we[i])) |-> tick[i]);

            a_r6_tick_while_low: assert property (@(posedge clk) disable iff (!rst_n)
                tick[i] |-> !pin_out[i]);

            a_r2_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_seen_q == '0) |-> !pin_out[i]);

            a_r7_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we[i] && cfg_en) |=> (!pin_out[i] && !tick[i]));

            a_r8_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_we[i] && !cfg_en) |=> (!pin_out[i] && !tick[i]));
        end
    endgenerate

endmodule

bind tick_prescaler psc_chk #(
    .NCH         (NCH),
    .N_W         (N_W),
    .M_W         (M_W),
    .SYNC_STAGES (SYNC_STAGES)
) chk_i (.*);

// File: tb/tick_prescaler_tb.sv
`timescale 1ns/1ps
module tick_prescaler_tb_top;
    localparam int NCH = 2;
    localparam int N_W = 16;
    localparam int M_W = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] cfg_we = '0;
    logic [N_W-1:0] cfg_div = '0;
    logic [M_W-1:0] cfg_sel = '0;
    logic           cfg_en = 1'b0;
    logic           cfg_ext = 1'b0;
    logic [NCH-1:0] ext_clk = '0;
    logic [NCH-1:0] tick;
    logic [NCH-1:0] pin_out;

    int n_chk = 0;
    int n_bad = 0;
    bit ext_run = 1'b0;

    always #4 clk = ~clk;

    // external count clock: period 8 system cycles when running
    initial begin
        #3;
        forever begin
            #32;
            if (ext_run) ext_clk = ~ext_clk;
        end
    end

    tick_prescaler #(.NCH(NCH), .N_W(N_W), .M_W(M_W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_div (cfg_div),
        .cfg_sel (cfg_sel),
        .cfg_en  (cfg_en),
        .cfg_ext (cfg_ext),
        .ext_clk (ext_clk),
        .tick    (tick),
        .pin_out (pin_out)
    );

    // internal source: {N, M, expected tick period, expected pin high cycles}
    localparam int NV = 7;
    localparam int VEC [NV][4] = '{
        '{4, 0,   8,   0},
        '{5, 0,  10,   0},
        '{3, 1,  12,   6},
        '{2, 1,   8,   4},
        '{2, 3,  32,  16},
        '{5, 2,  40,  20},
        '{3, 7, 768, 384}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int ch, input int n, input int m, input bit en, input bit ext);
        @(negedge clk);
        cfg_div = N_W'(n);
        cfg_sel = M_W'(m);
        cfg_en  = en;
        cfg_ext = ext;
        cfg_we  = '0;
        cfg_we[ch] = 1'b1;
        @(negedge clk);
        cfg_we = '0;
    endtask

    // period between two ticks and pin high cycles in that span; -1 on timeout
    task automatic measure(input int ch, output int period, output int high);
        int w;
        period = -1;
        high   = 0;
        w = 0;
        while (!tick[ch] && w < 3000) begin @(negedge clk); w++; end
        if (!tick[ch]) return;
        @(negedge clk);
        w = 1;
        high = pin_out[ch] ? 1 : 0;
        while (!tick[ch] && w < 3000) begin
            @(negedge clk);
            w++;
            if (!tick[ch] && pin_out[ch]) high++;
        end
        if (tick[ch]) period = w;
    endtask

    initial begin
        int p, h, seen;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tick == '0 && pin_out == '0, "R1 reset outputs", int'({tick, pin_out}), 0);
        rst_n = 1'b1;
        seen = 0;
        repeat (40) begin @(negedge clk); if (tick != '0 || pin_out != '0) seen++; end
        check(seen == 0, "R1 idle after reset", seen, 0);

        // vector walk, internal source (R2, R3, R4, R6)
        for (int v = 0; v < NV; v++) begin
            write_cfg(0, VEC[v][0], VEC[v][1], 1'b1, 1'b0);
            measure(0, p, h);
            check(p == VEC[v][2], (VEC[v][1] == 0) ? "R2 R4 tick period" : "R3 R4 wave period", p, VEC[v][2]);
            check(h == VEC[v][3], (VEC[v][1] == 0) ? "R2 pin held low" : "R3 R6 pin high width", h, VEC[v][3]);
        end

        // R7: restart in the middle of the high phase, N=3 M=1
        write_cfg(0, 3, 1, 1'b1, 1'b0);
        seen = 0;
        while (!pin_out[0] && seen < 100) begin @(negedge clk); seen++; end
        @(negedge clk);
        check(pin_out[0] == 1'b1, "R7 pin high before restart", pin_out[0], 1);
        write_cfg(0, 3, 1, 1'b1, 1'b0);
        seen = 0;
        if (pin_out[0]) seen++;
        for (int k = 0; k < 5; k++) begin @(negedge clk); if (pin_out[0]) seen++; end
        check(seen == 0, "R7 low phase after restart", seen, 0);
        @(negedge clk);
        check(pin_out[0] == 1'b1, "R7 high in 7th cycle", pin_out[0], 1);

        // R9: N=0 in pulse mode still ticks every 2 count cycles
        write_cfg(0, 0, 0, 1'b1, 1'b0);
        measure(0, p, h);
        check(p == 4, "R9 N=0 pulse period", p, 4);
        write_cfg(0, 1, 2, 1'b1, 1'b0);
        measure(0, p, h);
        check(p == 8, "R9 N=1 M=2 period", p, 8);

        // R5 and R10: channel 1 on external clock while channel 0 runs internal
        ext_run = 1'b1;
        write_cfg(0, 3, 1, 1'b1, 1'b0);
        write_cfg(1, 3, 1, 1'b1, 1'b1);
        measure(1, p, h);
        measure(1, p, h);
        check(p == 48, "R5 external wave period", p, 48);
        check(h == 24, "R5 external high width", h, 24);
        measure(0, p, h);
        check(p == 12, "R10 channel 0 unaffected", p, 12);
        write_cfg(1, 4, 0, 1'b1, 1'b1);
        measure(1, p, h);
        measure(1, p, h);
        check(p == 32, "R5 external pulse period", p, 32);
        measure(0, p, h);
        check(p == 12, "R10 channel 0 kept config", p, 12);

        // R8: disable with external clock still toggling
        write_cfg(1, 4, 2, 1'b0, 1'b1);
        seen = 0;
        repeat (200) begin @(negedge clk); if (tick[1] || pin_out[1]) seen++; end
        check(seen == 0, "R8 disabled channel quiet", seen, 0);
        measure(0, p, h);
        check(p == 12, "R10 channel 0 still running", p, 12);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule